// File: doc/BRIEF.md
# Pad Function Multiplexer with Engine and Keypad Override

This block sits between 96 bidirectional pads, grouped as six ports of 16 pins, and the logic that wants to use them. Each pad gets a 2-bit function code that picks which source drives its output value and output enable: the GPIO registers or one of three alternate-function sources. Pad input is always returned to every source, whatever the selection.

A 32-bit engine-select register adds a second level on ports 1 and 2. On those two ports, a pad whose code picks alternate function 1 and whose engine bit is set is driven by a programmable I/O engine. The engine then supplies both the output value and the output enable. On port 5, a per-pin keypad-active flag overrides every register setting. This flag is not affected by the register reset, so the keypad keeps control of its pins while the register state is held in reset.

Software reaches the registers through a single-cycle word-addressed write port and a combinational read port. The registers are the function codes, the GPIO output values, the GPIO output enables and the engine select.

Top module: `pad_func_mux`

## Requirements
- R1: While `rstN` is low, and after it is released with no writes, every function code, GPIO output register, GPIO enable register and the engine select read as zero. Every pad not under keypad override therefore drives output 0 with enable 0.
- R2: Function code encoding per pad: 2'b00 selects GPIO, 2'b01 alternate function 1, 2'b10 alternate function 2, 2'b11 alternate function 3. The selected source supplies both the pad output value and the pad output enable. An unselected source's output and enable have no effect on the pad.
- R3: The function codes of port p sit in two 16-bit registers. Address 2p holds pins 0–7 and address 2p+1 holds pins 8–15. Pin k of a register uses bits [2k+1:2k].
- R4: With code 00, pad (p,i) drives bit i of the GPIO output register at address 12+p. Its enable is bit i of the GPIO enable register at address 18+p, where 1 makes the pin an output.
- R5: The engine select register is at address 24. Bit n maps to port 1 pin n for n < 16, and to port 2 pin n−16 for n ≥ 16. When that bit is 1 and the pad's code is 01, engine output n and engine enable n drive the pad instead of alternate function 1.
- R6: An engine-select bit has no effect on a pad whose code is not 01. Pads outside ports 1 and 2 never take the engine.
- R7: On port 5, when `kpActive[i]` is 1, pad i drives `kpOut[i]` and `kpOe[i]` regardless of the code, the engine select, the GPIO registers and `rstN`.
- R8: `padInFwd` equals `padIn` at all times. `engIn[n]` equals the input of the pad that engine bit n maps to, and `kpIn[i]` equals the input of port 5 pin i.
- R9: A read returns the register at `regAddr`, zero-extended to 32 bits. Addresses 25–31 read as zero, and writes to them change no register and no pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low register reset |
| regWr | input | 1 | Write strobe, sampled on the rising clock edge |
| regAddr | input | 5 | Word address for read and write |
| regWData | input | 32 | Write data |
| regRData | output | 32 | Read data for `regAddr`, combinational |
| padIn | input | 96 | Pad input values, port p pin i at bit 16p+i |
| padOut | output | 96 | Pad output values |
| padOe | output | 96 | Pad output enables, 1 = drive |
| padInFwd | output | 96 | Pad input forwarded to GPIO and the alternate sources |
| engIn | output | 32 | Pad input forwarded to the engine |
| kpIn | output | 16 | Port 5 pad input forwarded to the keypad |
| af1Out | input | 96 | Alternate function 1 output values |
| af1Oe | input | 96 | Alternate function 1 output enables |
| af2Out | input | 96 | Alternate function 2 output values |
| af2Oe | input | 96 | Alternate function 2 output enables |
| af3Out | input | 96 | Alternate function 3 output values |
| af3Oe | input | 96 | Alternate function 3 output enables |
| engOut | input | 32 | Engine output values |
| engOe | input | 32 | Engine output enables |
| kpActive | input | 16 | Keypad override flag per port 5 pin |
| kpOut | input | 16 | Keypad output values |
| kpOe | input | 16 | Keypad output enables |

## Verification
The bench targets four kinds of error. The first is pairing the engine with the wrong port or the wrong half of the engine word, or letting it take over under codes other than 01; a wrong design would drive engine data onto an alternate-function-2 or GPIO pad. The second is taking the pad enable from alternate function 1 while the engine holds the pad, which would make the pad float or fight on engine-driven pins. The third is a keypad flag that loses to the mux, or that stops working while reset is held; a port 5 pin would then follow the registers. The fourth is a swapped low/high register half or a shifted 2-bit field, which would put a pin on the neighbouring pin's source. Unmapped addresses that alias onto real registers are also targeted. Random writes and source patterns are checked on every pad every cycle.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int NUM_PORTS   = 6;
  localparam int PINS        = 16;
  localparam int CODE_W      = 2;
  localparam int ADDR_W      = 5;
  localparam int DATA_W      = 32;
  localparam int NUM_PADS    = NUM_PORTS * PINS;
  // engine covers two consecutive ports starting at ENG_PORT_LO
  localparam int ENG_PORT_LO = 1;
  localparam int ENG_PORTS   = 2;
  localparam int ENG_W       = ENG_PORTS * PINS;
  localparam int KP_PORT     = 5;
  // register address map
  localparam int PINS_PER_REG = 16 / CODE_W;
  localparam int FSEL_REGS    = NUM_PORTS * (PINS / PINS_PER_REG);
  localparam int OUT_BASE     = FSEL_REGS;
  localparam int OE_BASE      = OUT_BASE + NUM_PORTS;
  localparam int ENG_ADDR     = OE_BASE + NUM_PORTS;

  typedef enum logic [CODE_W-1:0] {
    FN_GPIO = 2'b00,
    FN_ALT1 = 2'b01,
    FN_ALT2 = 2'b10,
    FN_ALT3 = 2'b11
  } fn_e;

  typedef struct packed {
    logic [FSEL_REGS-1:0] fselWr;
    logic [NUM_PORTS-1:0] outWr;
    logic [NUM_PORTS-1:0] oeWr;
    logic                 engWr;
    logic [ADDR_W-1:0]    rdIdx;
  } strobe_t;
endpackage

// File: rtl/pmx_ctrl.sv
module pmx_ctrl
  import pmx_pkg::*;
(
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           stb
);
  always_comb begin
    stb = '0;
    for (int k = 0; k < FSEL_REGS; k++)
      stb.fselWr[k] = regWr && (regAddr == ADDR_W'(k));
    for (int k = 0; k < NUM_PORTS; k++) begin
      stb.outWr[k] = regWr && (regAddr == ADDR_W'(OUT_BASE + k));
      stb.oeWr[k]  = regWr && (regAddr == ADDR_W'(OE_BASE + k));
    end
    stb.engWr = regWr && (regAddr == ADDR_W'(ENG_ADDR));
    stb.rdIdx = regAddr;
  end
endmodule

// File: rtl/pmx_dp.sv
module pmx_dp
  import pmx_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [DATA_W-1:0]          wData,
  output logic [DATA_W-1:0]          rdData,
  input  logic [NUM_PADS-1:0]        af1Out,
  input  logic [NUM_PADS-1:0]        af1Oe,
  input  logic [NUM_PADS-1:0]        af2Out,
  input  logic [NUM_PADS-1:0]        af2Oe,
  input  logic [NUM_PADS-1:0]        af3Out,
  input  logic [NUM_PADS-1:0]        af3Oe,
  input  logic [ENG_W-1:0]           engOut,
  input  logic [ENG_W-1:0]           engOe,
  input  logic [PINS-1:0]            kpActive,
  input  logic [PINS-1:0]            kpOut,
  input  logic [PINS-1:0]            kpOe,
  output logic [NUM_PADS-1:0]        padOut,
  output logic [NUM_PADS-1:0]        padOe,
  output logic [NUM_PADS*CODE_W-1:0] funcCodes,
  output logic [ENG_W-1:0]           engSel
);
  logic [FSEL_REGS-1:0][15:0]    fselReg;
  logic [NUM_PORTS-1:0][PINS-1:0] outReg;
  logic [NUM_PORTS-1:0][PINS-1:0] oeReg;
  logic [ENG_W-1:0]               engReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fselReg <= '0;
      outReg  <= '0;
      oeReg   <= '0;
      engReg  <= '0;
    end else begin
      for (int k = 0; k < FSEL_REGS; k++)
        if (stb.fselWr[k]) fselReg[k] <= wData[15:0];
      for (int k = 0; k < NUM_PORTS; k++) begin
        if (stb.outWr[k]) outReg[k] <= wData[PINS-1:0];
        if (stb.oeWr[k])  oeReg[k]  <= wData[PINS-1:0];
      end
      if (stb.engWr) engReg <= wData[ENG_W-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < FSEL_REGS; k++)
      if (stb.rdIdx == ADDR_W'(k)) rdData = DATA_W'(fselReg[k]);
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (stb.rdIdx == ADDR_W'(OUT_BASE + k)) rdData = DATA_W'(outReg[k]);
      if (stb.rdIdx == ADDR_W'(OE_BASE + k))  rdData = DATA_W'(oeReg[k]);
    end
    if (stb.rdIdx == ADDR_W'(ENG_ADDR)) rdData = DATA_W'(engReg);
  end

  assign engSel = engReg;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar i = 0; i < PINS; i++) begin : g_pin
      localparam int N   = p * PINS + i;
      localparam int REG = p * (PINS / PINS_PER_REG) + i / PINS_PER_REG;
      localparam int LSB = CODE_W * (i % PINS_PER_REG);
      fn_e  code;
      logic engHit, engO, engE;
      logic muxO, muxE;

      assign code = fn_e'(fselReg[REG][LSB +: CODE_W]);
      assign funcCodes[N*CODE_W +: CODE_W] = code;

      if (p >= ENG_PORT_LO && p < ENG_PORT_LO + ENG_PORTS) begin : g_eng
        localparam int E = (p - ENG_PORT_LO) * PINS + i;
        assign engHit = engReg[E];
        assign engO   = engOut[E];
        assign engE   = engOe[E];
      end else begin : g_noeng
        assign engHit = 1'b0;
        assign engO   = 1'b0;
        assign engE   = 1'b0;
      end

      always_comb begin
        unique case (code)
          FN_GPIO: begin muxO = outReg[p][i]; muxE = oeReg[p][i]; end
          FN_ALT1: begin
            muxO = engHit ? engO : af1Out[N];
            muxE = engHit ? engE : af1Oe[N];
          end
          FN_ALT2: begin muxO = af2Out[N]; muxE = af2Oe[N]; end
          default: begin muxO = af3Out[N]; muxE = af3Oe[N]; end
        endcase
      end

      if (p == KP_PORT) begin : g_kp
        assign padOut[N] = kpActive[i] ? kpOut[i] : muxO;
        assign padOe[N]  = kpActive[i] ? kpOe[i]  : muxE;
      end else begin : g_nokp
        assign padOut[N] = muxO;
        assign padOe[N]  = muxE;
      end
    end
  end
endmodule

// File: rtl/pad_func_mux.sv
module pad_func_mux
  import pmx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWData,
  output logic [DATA_W-1:0]   regRData,
  input  logic [NUM_PADS-1:0] padIn,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] padOe,
  output logic [NUM_PADS-1:0] padInFwd,
  output logic [ENG_W-1:0]    engIn,
  output logic [PINS-1:0]     kpIn,
  input  logic [NUM_PADS-1:0] af1Out,
  input  logic [NUM_PADS-1:0] af1Oe,
  input  logic [NUM_PADS-1:0] af2Out,
  input  logic [NUM_PADS-1:0] af2Oe,
  input  logic [NUM_PADS-1:0] af3Out,
  input  logic [NUM_PADS-1:0] af3Oe,
  input  logic [ENG_W-1:0]    engOut,
  input  logic [ENG_W-1:0]    engOe,
  input  logic [PINS-1:0]     kpActive,
  input  logic [PINS-1:0]     kpOut,
  input  logic [PINS-1:0]     kpOe
);
  strobe_t                    stb;
  logic [NUM_PADS*CODE_W-1:0] funcCodes;
  logic [ENG_W-1:0]           engSel;

  pmx_ctrl u_ctrl (
    .regWr  (regWr),
    .regAddr(regAddr),
    .stb    (stb)
  );

  pmx_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wData    (regWData),
    .rdData   (regRData),
    .af1Out   (af1Out),
    .af1Oe    (af1Oe),
    .af2Out   (af2Out),
    .af2Oe    (af2Oe),
    .af3Out   (af3Out),
    .af3Oe    (af3Oe),
    .engOut   (engOut),
    .engOe    (engOe),
    .kpActive (kpActive),
    .kpOut    (kpOut),
    .kpOe     (kpOe),
    .padOut   (padOut),
    .padOe    (padOe),
    .funcCodes(funcCodes),
    .engSel   (engSel)
  );

  assign padInFwd = padIn;
  assign engIn    = padIn[ENG_PORT_LO*PINS +: ENG_W];
  assign kpIn     = padIn[KP_PORT*PINS +: PINS];
endmodule

// File: rtl/pmx_chk.sv
module pmx_chk
  import pmx_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       regWr,
  input logic [ADDR_W-1:0]          regAddr,
  input logic [DATA_W-1:0]          regWData,
  input logic [NUM_PADS-1:0]        padOut,
  input logic [NUM_PADS-1:0]        padOe,
  input logic [NUM_PADS-1:0]        af3Out,
  input logic [NUM_PADS-1:0]        af3Oe,
  input logic [ENG_W-1:0]           engOut,
  input logic [ENG_W-1:0]           engOe,
  input logic [PINS-1:0]            kpActive,
  input logic [PINS-1:0]            kpOut,
  input logic [PINS-1:0]            kpOe,
  input logic [NUM_PADS*CODE_W-1:0] funcCodes,
  input logic [ENG_W-1:0]           engSel
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (funcCodes == '0 && engSel == '0)) else $error("reset clear"); // R1

  AST_ENG_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_W'(ENG_ADDR)) |=> (engSel == $past(regWData[ENG_W-1:0])))
    else $error("engine select write"); // R5

  for (genvar i = 0; i < PINS; i++) begin : g_kpa
    AST_KP_WINS: assert property (@(posedge clk) disable iff (!rstN)
      kpActive[i] |-> (padOut[KP_PORT*PINS+i] == kpOut[i] && padOe[KP_PORT*PINS+i] == kpOe[i]))
      else $error("keypad override"); // R7
  end

  for (genvar e = 0; e < ENG_W; e++) begin : g_enga
    localparam int N = ENG_PORT_LO * PINS + e;
    AST_ENG_TAKEOVER: assert property (@(posedge clk) disable iff (!rstN)
      (funcCodes[N*CODE_W +: CODE_W] == 2'b01 && engSel[e]) |->
        (padOut[N] == engOut[e] && padOe[N] == engOe[e]))
      else $error("engine takeover"); // R5
  end

  for (genvar n = 0; n < KP_PORT * PINS; n++) begin : g_af3a
    AST_ALT3_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
      (funcCodes[n*CODE_W +: CODE_W] == 2'b11) |-> (padOut[n] == af3Out[n] && padOe[n] == af3Oe[n]))
      else $error("alt3 route"); // R2
  end
endmodule

bind pad_func_mux pmx_chk u_chk (.*);

// File: tb/sim_pad_func_mux.sv
`timescale 1ns/1ps
module sim_pad_func_mux;
  localparam int NP = 96;

  logic        clk = 1'b0;
  logic        rstN, regWr;
  logic [4:0]  regAddr;
  logic [31:0] regWData, regRData;
  logic [NP-1:0] padIn, padOut, padOe, padInFwd;
  logic [NP-1:0] af1Out, af1Oe, af2Out, af2Oe, af3Out, af3Oe;
  logic [31:0] engIn, engOut, engOe;
  logic [15:0] kpIn, kpActive, kpOut, kpOe;

  int checks = 0;
  int failures = 0;

  // reference state
  logic [15:0] mFsel [12];
  logic [15:0] mOut [6];
  logic [15:0] mOe [6];
  logic [31:0] mEng;

  always #10 clk = ~clk;

  pad_func_mux u0 (.*);

  task automatic modelClear();
    for (int k = 0; k < 12; k++) mFsel[k] = '0;
    for (int k = 0; k < 6; k++) begin mOut[k] = '0; mOe[k] = '0; end
    mEng = '0;
  endtask

  function automatic logic [31:0] expRead(input int a);
    if (a < 12) return {16'h0, mFsel[a]};
    if (a < 18) return {16'h0, mOut[a-12]};
    if (a < 24) return {16'h0, mOe[a-18]};
    if (a == 24) return mEng;
    return 32'h0;
  endfunction

  task automatic expPad(input int n, output logic eo, output logic ee, output string tag);
    int p, i, code, e;
    p = n / 16; i = n % 16;
    code = int'((mFsel[2*p + i/8] >> (2*(i%8))) & 16'h3);
    e = (p - 1) * 16 + i;
    if (code == 0) begin eo = mOut[p][i]; ee = mOe[p][i]; tag = "R4"; end
    else if (code == 1) begin
      if ((p == 1 || p == 2) && mEng[e]) begin eo = engOut[e]; ee = engOe[e]; tag = "R5"; end
      else begin
        eo = af1Out[n]; ee = af1Oe[n];
        tag = ((p == 1 || p == 2) || mEng != 0) ? "R6" : "R2";
      end
    end
    else if (code == 2) begin eo = af2Out[n]; ee = af2Oe[n]; tag = (p == 1 || p == 2) ? "R6" : "R2"; end
    else begin eo = af3Out[n]; ee = af3Oe[n]; tag = "R2"; end
    if (p == 5 && kpActive[i]) begin eo = kpOut[i]; ee = kpOe[i]; tag = "R7"; end
    else if (!rstN) tag = "R1";
  endtask

  task automatic checkAll();
    logic eo, ee;
    string tag;
    logic [31:0] er;
    for (int n = 0; n < NP; n++) begin
      expPad(n, eo, ee, tag);
      checks++;
      if (padOut[n] !== eo || padOe[n] !== ee) begin
        failures++;
        $display("FAIL %s pad %0d out/oe got %b%b expected %b%b", tag, n, padOut[n], padOe[n], eo, ee);
      end
    end
    checks++;
    if (padInFwd !== padIn || engIn !== padIn[47:16] || kpIn !== padIn[95:80]) begin
      failures++;
      $display("FAIL R8 input forward got %h/%h/%h expected %h/%h/%h",
               padInFwd, engIn, kpIn, padIn, padIn[47:16], padIn[95:80]);
    end
    er = rstN ? expRead(int'(regAddr)) : 32'h0;
    checks++;
    if (regRData !== er) begin
      failures++;
      $display("FAIL %s read addr %0d got %h expected %h",
               (regAddr < 12) ? "R3" : (rstN ? "R9" : "R1"), regAddr, regRData, er);
    end
  endtask

  task automatic shuffle();
    padIn  = {$urandom, $urandom, $urandom};
    af1Out = {$urandom, $urandom, $urandom};
    af1Oe  = {$urandom, $urandom, $urandom};
    af2Out = {$urandom, $urandom, $urandom};
    af2Oe  = {$urandom, $urandom, $urandom};
    af3Out = {$urandom, $urandom, $urandom};
    af3Oe  = {$urandom, $urandom, $urandom};
    engOut = $urandom;
    engOe  = $urandom;
    kpActive = 16'($urandom);
    kpOut  = 16'($urandom);
    kpOe   = 16'($urandom);
  endtask

  // write, then re-randomize sources, pick a read address, compare at negedge
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = 5'(a); regWData = d;
    @(posedge clk);
    #1;
    regWr = 1'b0;
    if (a < 12) mFsel[a] = d[15:0];
    else if (a < 18) mOut[a-12] = d[15:0];
    else if (a < 24) mOe[a-18] = d[15:0];
    else if (a == 24) mEng = d;
    shuffle();
    regAddr = 5'($urandom_range(0, 31));
    @(negedge clk);
    checkAll();
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWr = 1'b0; regAddr = '0; regWData = '0;
    modelClear();
    shuffle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkAll();                         // R1 and R7 under reset
    kpActive = 16'hFFFF; #1; checkAll(); // R7 during reset
    rstN = 1'b1;
    @(negedge clk);
    checkAll();                         // R1 after release

    wr(12, 32'h0000_1234);              // R4 port 0 outputs
    wr(18, 32'h0000_00FF);              // R4 port 0 enables
    wr(2,  32'h0000_5555);              // R3 port 1 low half to alt1
    wr(3,  32'h0000_5555);
    wr(24, 32'hF0F0_A5A5);              // R5 engine on mixed pins
    wr(4,  32'h0000_AAAA);              // R6 port 2 low on alt2 with engine bits set
    wr(5,  32'h0000_0F5F);
    wr(6,  32'h0000_5555);              // R6 port 3 alt1, no engine
    wr(0,  32'h0000_E4E4);              // R2 mixed codes
    wr(10, 32'h0000_FFFF);              // R7 port 5 alt3 vs keypad
    wr(11, 32'h0000_5555);
    wr(25, 32'hFFFF_FFFF);              // R9 unmapped write
    wr(31, 32'hFFFF_FFFF);              // R9 unmapped write

    for (int k = 0; k < 400; k++)
      wr($urandom_range(0, 31), $urandom);

    // reset mid-run with keypad active
    @(negedge clk);
    rstN = 1'b0;
    modelClear();
    #1;
    checkAll();                         // R1 async clear, R7 kept
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < 40; k++)
      wr($urandom_range(0, 24), $urandom);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule